// File: doc/BRIEF.md
# Background Dither Calibration Correlator

This block is the digital half of a background gain-calibration loop for one stage of a pipelined converter. Each cycle it emits a pseudo-random polarity bit that the analog side uses to add or subtract a known calibration step at the stage input. The digitized result returns a fixed number of cycles later. The block multiplies each returning code by the polarity that was in force when that sample was taken, and sums the products over a window of 2^M samples. It then divides the sum by 2^M with an arithmetic shift. The input signal is uncorrelated with the polarity sequence, so it averages toward zero, while the calibration step adds up coherently. The quotient is therefore a digital measurement of the step as the stage actually produced it.

Each window publishes the measurement and its difference from the ideal digital value, which is the stage error estimate, together with a one-cycle strobe. Every code is also passed through with the dither removed digitally: the measured step, signed by the aligned polarity, is subtracted from it. Conversions are never paused. The ideal value and the window length are programmable inputs. The step amplitude is meant to be a small fraction of full scale, so that the input swing is largely preserved.

Top module: `pncal_core`

## Requirements
- R1: The polarity source is a 23-bit Fibonacci shift register loaded with the non-zero parameter SEED on reset. Its next state is {s[21:0], s[22]^s[17]}, which gives the maximal-length polynomial x^23+x^18+1. `pn_out` is bit 22 of the current state, and the state is never all zeros.
- R2: A `pn_out` value of 1 means +1 and 0 means -1. The code on `code_in` in cycle c is demodulated with the `pn_out` value of cycle c-LAT. In the first LAT cycles after reset, the polarity used is -1.
- R3: The block sums the demodulated codes (+code for +1, -code for -1) over 2^M consecutive cycles. When the window closes, `vcal_meas` becomes the sum arithmetically shifted right by M, which is the floor of the mean. The sum then clears, and the next window starts with the next code.
- R4: At the close of each window, `err_est` becomes the new `vcal_meas` minus the value of `vcal_ideal` present at the window's last code. It is published in the same cycle as `vcal_meas`.
- R5: M is taken from `win_log2` at reset and again at every window boundary, and is held constant within a window. Requested values below 8 are raised to 8, and values above 20 are lowered to 20.
- R6: `est_vld` is high for exactly one cycle: the cycle after the edge that takes a window's last code. `vcal_meas` and `err_est` change only in that cycle.
- R7: One cycle after each code, `corr_out` equals that code minus p x `vcal_meas`. Here p is the code's aligned polarity (R2) and `vcal_meas` is the value published before that edge.
- R8: While reset is high, `corr_out`, `vcal_meas`, `err_est` and `est_vld` are zero, and `pn_out` is bit 22 of SEED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | CW | Signed digitized back-end code, one per cycle |
| vcal_ideal | input | CW | Signed ideal digital calibration step |
| win_log2 | input | 5 | Requested window exponent M |
| pn_out | output | 1 | Injection polarity (1 = +1, 0 = -1) |
| corr_out | output | CW+1 | Signed code with the dither removed |
| vcal_meas | output | CW | Signed measured calibration step |
| err_est | output | CW+1 | Signed measured-minus-ideal error |
| est_vld | output | 1 | One-cycle strobe when a new estimate is published |

## Verification
On every cycle the assertions check the following. The shift-register state is never zero. The window exponent in use stays between 8 and 20. The strobe lasts one cycle, and strobes are never closer together than the shortest window. The published measurement and error hold steady except in a strobe cycle. Only the bench scenarios can show the numerical results: the exact polarity sequence, the alignment delay, the floor of each window's mean and the error, when a new window length takes effect, and the subtracted output. They are checked against a model built from the requirements, using constant, ramping and near-full-scale inputs, a clamped window request, and a reset in mid-window.

// File: rtl/pncal_pkg.sv
package pncal_pkg;
  localparam int LOG2W = 5;

  function automatic logic [LOG2W-1:0] clamp_log2(input logic [LOG2W-1:0] req,
                                                  input int lo, input int hi);
    if (int'(req) < lo) return LOG2W'(lo);
    if (int'(req) > hi) return LOG2W'(hi);
    return req;
  endfunction
endpackage

// File: rtl/pncal_lfsr.sv
module pncal_lfsr #(
  parameter int          SW   = 23,
  parameter int          TAP  = 18,
  parameter logic [SW-1:0] SEED = 23'h2A5F3C
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] state_q,
  output logic          pn
);
  logic fb;
  assign fb = state_q[SW-1] ^ state_q[TAP-1];

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= {state_q[SW-2:0], fb};
  end

  assign pn = state_q[SW-1];
endmodule

// File: rtl/pncal_align.sv
module pncal_align #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pn_in,
  output logic pn_al
);
  generate
    if (LAT == 1) begin : g_one
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= pn_in;
      end
      assign pn_al = q;
    end else begin : g_many
      logic [LAT-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[LAT-2:0], pn_in};
      end
      assign pn_al = sr[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/pncal_accum.sv
module pncal_accum
  import pncal_pkg::*;
#(
  parameter int CW   = 12,
  parameter int MMIN = 8,
  parameter int MMAX = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pn_al,
  input  logic signed [CW-1:0] code_in,
  input  logic signed [CW-1:0] vcal_ideal,
  input  logic [LOG2W-1:0]     win_log2,
  output logic signed [CW-1:0] vcal_meas,
  output logic signed [CW:0]   err_est,
  output logic                 est_vld,
  output logic [LOG2W-1:0]     m_cur
);
  localparam int ACCW = CW + MMAX + 1;
  localparam int CNTW = MMAX + 1;

  logic signed [ACCW-1:0] acc_q, term, acc_nx, shifted;
  logic [CNTW-1:0]        cnt_q, lim;
  logic                   last;
  logic signed [CW-1:0]   meas_d;

  always_comb begin
    term    = {{(ACCW-CW){code_in[CW-1]}}, code_in};
    if (!pn_al) term = -term;
    acc_nx  = acc_q + term;
    shifted = acc_nx >>> m_cur;
    meas_d  = shifted[CW-1:0];
    lim     = (CNTW'(1) << m_cur) - CNTW'(1);
    last    = (cnt_q == lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      m_cur     <= clamp_log2(win_log2, MMIN, MMAX);
      vcal_meas <= '0;
      err_est   <= '0;
      est_vld   <= 1'b0;
    end else if (last) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      m_cur     <= clamp_log2(win_log2, MMIN, MMAX);
      vcal_meas <= meas_d;
      err_est   <= {meas_d[CW-1], meas_d} - {vcal_ideal[CW-1], vcal_ideal};
      est_vld   <= 1'b1;
    end else begin
      acc_q   <= acc_nx;
      cnt_q   <= cnt_q + CNTW'(1);
      est_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/pncal_core.sv
module pncal_core
  import pncal_pkg::*;
#(
  parameter int            CW   = 12,
  parameter int            LAT  = 4,
  parameter int            MMIN = 8,
  parameter int            MMAX = 20,
  parameter logic [22:0]   SEED = 23'h2A5F3C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [CW-1:0] code_in,
  input  logic signed [CW-1:0] vcal_ideal,
  input  logic [4:0]           win_log2,
  output logic                 pn_out,
  output logic signed [CW:0]   corr_out,
  output logic signed [CW-1:0] vcal_meas,
  output logic signed [CW:0]   err_est,
  output logic                 est_vld
);
  logic [22:0]      lfsr_q;
  logic             pn_al;
  logic [LOG2W-1:0] m_cur;
  logic signed [CW:0] code_x, meas_x;

  pncal_lfsr #(.SW(23), .TAP(18), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .state_q(lfsr_q), .pn(pn_out));

  pncal_align #(.LAT(LAT)) u_align (
    .clk(clk), .rst(rst), .pn_in(pn_out), .pn_al(pn_al));

  pncal_accum #(.CW(CW), .MMIN(MMIN), .MMAX(MMAX)) u_accum (
    .clk(clk), .rst(rst), .pn_al(pn_al), .code_in(code_in),
    .vcal_ideal(vcal_ideal), .win_log2(win_log2), .vcal_meas(vcal_meas),
    .err_est(err_est), .est_vld(est_vld), .m_cur(m_cur));

  assign code_x = {code_in[CW-1], code_in};
  assign meas_x = {vcal_meas[CW-1], vcal_meas};

  always_ff @(posedge clk) begin
    if (rst)        corr_out <= '0;
    else if (pn_al) corr_out <= code_x - meas_x;
    else            corr_out <= code_x + meas_x;
  end
endmodule

// File: rtl/pncal_core_chk.sv
module pncal_core_chk #(
  parameter int CW   = 12,
  parameter int MMIN = 8,
  parameter int MMAX = 20
) (
  input logic                 clk,
  input logic                 rst,
  input logic [22:0]          lfsr_q,
  input logic [4:0]           m_cur,
  input logic                 est_vld,
  input logic signed [CW-1:0] vcal_meas,
  input logic signed [CW:0]   err_est
);
  logic [MMAX+1:0] gap;
  always_ff @(posedge clk) begin
    if (rst)          gap <= '0;
    else if (est_vld) gap <= '0;
    else              gap <= gap + 1'b1;
  end

  assert_lfsr_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
  assert_window_clamped_R5: assert property (@(posedge clk) disable iff (rst)
    (int'(m_cur) >= MMIN) && (int'(m_cur) <= MMAX));
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    est_vld |=> !est_vld);
  assert_strobe_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    est_vld |-> (gap >= (MMAX+2)'((1 << MMIN) - 1)));
  assert_meas_held_R6: assert property (@(posedge clk) disable iff (rst)
    !est_vld |-> ($stable(vcal_meas) && $stable(err_est)));
endmodule

bind pncal_core pncal_core_chk #(.CW(CW), .MMIN(MMIN), .MMAX(MMAX)) u_chk (
  .clk(clk), .rst(rst), .lfsr_q(lfsr_q), .m_cur(m_cur), .est_vld(est_vld),
  .vcal_meas(vcal_meas), .err_est(err_est));

// File: tb/pncal_core_bench.sv
module pncal_core_bench;
  localparam int CW = 12;
  localparam int LAT = 4;
  localparam logic [22:0] SEED = 23'h2A5F3C;

  logic clk = 1'b0, rst = 1'b1;
  logic signed [CW-1:0] code_in = '0, vcal_ideal = '0;
  logic [4:0] win_log2 = 5'd8;
  logic pn_out, est_vld;
  logic signed [CW:0] corr_out, err_est;
  logic signed [CW-1:0] vcal_meas;

  always #4 clk = ~clk;

  pncal_core #(.CW(CW), .LAT(LAT), .SEED(SEED)) u_pncal_core (
    .clk(clk), .rst(rst), .code_in(code_in), .vcal_ideal(vcal_ideal),
    .win_log2(win_log2), .pn_out(pn_out), .corr_out(corr_out),
    .vcal_meas(vcal_meas), .err_est(err_est), .est_vld(est_vld));

  typedef struct { int corr; bit pn; bit vld; int meas; int err; } exp_t;
  exp_t sb[$];
  int checks = 0, errs = 0;
  bit done = 0;

  logic [22:0] m_lfsr;
  bit          m_hist[$];
  longint      m_acc;
  int          m_cnt, m_m, m_meas, m_err;

  function automatic int clampm(int v);
    return (v < 8) ? 8 : (v > 20) ? 20 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic model_reset();
    m_lfsr = SEED; m_acc = 0; m_cnt = 0; m_meas = 0; m_err = 0;
    m_m = clampm(int'(win_log2));
    m_hist.delete();
    for (int i = 0; i < LAT; i++) m_hist.push_back(1'b0);
  endtask

  // driver: called at a falling edge, drives one code and queues expectations
  task automatic step(input int sig, input int amp);
    exp_t e;
    bit pal, pn_now;
    int code, term;
    pn_now = m_lfsr[22];
    m_hist.push_back(pn_now);
    pal = m_hist.pop_front();
    code = sig + (pal ? amp : -amp);
    code_in = CW'(code);
    e.corr = code - (pal ? m_meas : -m_meas);
    m_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
    e.pn = m_lfsr[22];
    term = pal ? code : -code;
    m_acc += term;
    m_cnt++;
    e.vld = 0;
    if (m_cnt == (1 << m_m)) begin
      m_meas = int'(m_acc >>> m_m);
      m_err  = m_meas - int'(vcal_ideal);
      m_acc = 0; m_cnt = 0;
      m_m = clampm(int'(win_log2));
      e.vld = 1;
    end
    e.meas = m_meas; e.err = m_err;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compares results just after each rising edge
  always begin
    exp_t e;
    @(posedge clk); #2;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      chk("R7 corr_out", int'(corr_out), e.corr);
      chk("R1 pn_out", int'(pn_out), int'(e.pn));
      chk("R6 est_vld", int'(est_vld), int'(e.vld));
      chk("R3 vcal_meas", int'(vcal_meas), e.meas);
      chk("R4 err_est", int'(err_est), e.err);
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 corr_out", int'(corr_out), 0);
    chk("R8 vcal_meas", int'(vcal_meas), 0);
    chk("R8 err_est", int'(err_est), 0);
    chk("R8 est_vld", int'(est_vld), 0);
    chk("R8 pn_out", int'(pn_out), int'(SEED[22]));
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // R2 R3 R4: constant input, exact step, window 256
    win_log2 = 5'd8; vcal_ideal = 12'sd100;
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 520; i++) step(37, 100);
    // R5: request below range, must take effect only at next boundary as 256
    win_log2 = 5'd3; vcal_ideal = 12'sd96;
    for (int i = 0; i < 600; i++) step(((i * 13) % 1500) - 750, 103);
    // R5: longer window of 512, triangle input
    win_log2 = 5'd9;
    for (int i = 0; i < 1100; i++) step((i % 200 < 100) ? (i % 200) * 9 - 450 : 1350 - (i % 200) * 9, 90);
    // R3: near full-scale alternating input
    win_log2 = 5'd8; vcal_ideal = 12'sd120;
    for (int i = 0; i < 600; i++) step((i % 2 == 0) ? 1940 : -1940, 100);
    // R8 R2: reset in mid-window, then restart
    for (int i = 0; i < 77; i++) step(-300, 80);
    do_reset();
    for (int i = 0; i < 300; i++) step(250, 64);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule